// File: doc/BRIEF.md
# Six-Lane Nibble Transmit Serializer with Tristate Control

This block turns parallel fabric-side words into paired bit slots for the six data lanes of one nibble of a source-synchronous output interface. Each fast-clock cycle it emits two bits per lane, one for each half-cycle of a double-data-rate launch. One fast cycle therefore carries two serial bit times. A nibble-wide parameter sets the ratio to 2:1, 4:1 or 8:1, which is also the width of each lane's parallel word. A new word is taken every RATIO/2 fast cycles, and the block signals that moment on a strobe output.

Each lane has a tristate output that comes from one of two sources, chosen per lane at elaboration. The first source is a direct per-lane tristate input. The second is a nibble-wide write-enable word that travels with the data, is inverted, and is serialized so that each enable bit covers both slots of one fast cycle, which is two data bits. When gating is enabled, the same enable bits can also force the data of every lane except lane 1 to its initial value. A global reset or a per-lane reset drives each lane's data to a configured per-lane value and drives its tristate to a nibble-wide value.

Top module: `nts_nibble_ser`

## Requirements
- R1: `RATIO` is 2, 4 or 8, and each lane's word is `RATIO` bits wide. `o_take` is high on the first clock edge after reset is released, and then on every `RATIO/2`-th edge after that. `i_word` and `i_wren` are sampled on each edge where `o_take` is high.
- R2: Bit 0 of a word is sent first. In fast cycle j of a word period, lane l carries word bit 2j on `o_data[2l]` (first slot) and word bit 2j+1 on `o_data[2l+1]` (second slot).
- R3: A word sampled on edge e appears on the outputs after edges e+2P through e+3P-1, where P = `RATIO/2`. This latency is the same on every lane.
- R4: For a lane whose `TRI_FROM_WE` bit is 0, both tristate slots after an edge equal the `i_tri` bit for that lane sampled on that edge.
- R5: For a lane whose `TRI_FROM_WE` bit is 1, both tristate slots in fast cycle j of a word period equal the inverse of bit j of the enable word that was sampled together with that data word. Each enable bit therefore covers two data bits.
- R6: At a ratio of 2, only the direct tristate input is allowed. Any set bit in `TRI_FROM_WE` stops elaboration with an error, and a ratio-2 nibble that uses the direct tristate input operates normally.
- R7: From the first edge at which `i_rst` or the lane's own `i_lane_rst` bit is high, and for as long as it stays high, both data slots of that lane equal `INIT_VAL[l]`.
- R8: From the first edge at which `i_rst` or the lane's own `i_lane_rst` bit is high, and for as long as it stays high, both tristate slots of that lane equal `TRI_INIT`.
- R9: When `GATE_EN` is 1, a lane other than lane 1 drives `INIT_VAL[l]` in both data slots during every fast cycle whose serialized enable bit is 0. In cycles whose enable bit is 1, it drives its data.
- R10: Lane 1 is never gated. It always drives its serialized data, whatever `GATE_EN` and the enable bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| i_clk | input | 1 | Fast bit clock (two slots per cycle) |
| i_rst | input | 1 | Global synchronous reset, active high |
| i_lane_rst | input | LANES | Per-lane transmit reset, active high |
| i_word | input | LANES*RATIO | Parallel words; lane l uses bits [l*RATIO +: RATIO] |
| i_wren | input | RATIO/2 | Write-enable word; bit j covers fast cycle j |
| i_tri | input | LANES | Direct per-lane tristate input |
| o_take | output | 1 | High in the cycle whose closing edge samples a new word |
| o_data | output | 2*LANES | Data slots; [2l] is sent first, [2l+1] second |
| o_tri | output | 2*LANES | Tristate slots, same layout as o_data |

## Verification
The strobe is combinational, so it is checked before each edge. The data and enable fields of the word sampled at edge e are due after edge e+2P+j in cycle j. The direct tristate value is due after the very edge that samples it. The bench keeps its own count of edges since reset was released, drives inputs at falling edges, and samples each result at the falling edge that follows the rising edge where it becomes due. Reset values are checked after the first rising edge with reset high and again while the reset is held. Three configurations (ratios 8, 4 and 2, with different tristate selections, gating settings and initial values) are swept over sixteen word periods each.

// File: rtl/nts_pkg.sv
package nts_pkg;
   localparam int NTS_LANES   = 6;
   localparam int NTS_UNGATED = 1;

   // width of a phase counter covering p cycles (at least one bit)
   function automatic int cnt_w(input int p);
      return (p > 1) ? $clog2(p) : 1;
   endfunction
endpackage

// File: rtl/nts_phase.sv
module nts_phase #(
   parameter int P  = 4,
   parameter int CW = nts_pkg::cnt_w(P)
) (
   input  logic          i_clk,
   input  logic          i_rst,
   output logic [CW-1:0] o_cnt,
   output logic          o_take
);
   localparam logic [CW-1:0] LAST = CW'(P - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge i_clk) begin
      if (i_rst)              cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign o_cnt  = cnt_q;
   assign o_take = (cnt_q == '0);

   // R1: take strobe returns after the last phase of each period
   a_r1_take_return: assert property (@(posedge i_clk) disable iff (i_rst)
      (cnt_q == LAST) |=> o_take);

   if (P > 1) begin : g_gap
      // R1: no two takes back to back when a period spans several cycles
      a_r1_take_gap: assert property (@(posedge i_clk) disable iff (i_rst)
         o_take |=> !o_take);
   end
endmodule

// File: rtl/nts_hold2.sv
module nts_hold2 #(
   parameter int W = 8
) (
   input  logic         i_clk,
   input  logic         i_rst,
   input  logic         i_load,
   input  logic [W-1:0] i_d,
   output logic [W-1:0] o_q
);
   logic [W-1:0] s1_q, s2_q;

   always_ff @(posedge i_clk) begin
      if (i_rst) begin
         s1_q <= '0;
         s2_q <= '0;
      end else if (i_load) begin
         s1_q <= i_d;
         s2_q <= s1_q;
      end
   end

   assign o_q = s2_q;
endmodule

// File: rtl/nts_lane.sv
module nts_lane #(
   parameter int R        = 8,
   parameter int CW       = 2,
   parameter bit INIT     = 1'b0,
   parameter bit GATED    = 1'b0,
   parameter bit TRI_WE   = 1'b0,
   parameter bit TRI_INIT = 1'b1
) (
   input  logic          i_clk,
   input  logic          i_rst_g,
   input  logic          i_rst,
   input  logic          i_first,
   input  logic [CW-1:0] i_cnt,
   input  logic [R-1:0]  i_word,
   input  logic          i_en,
   input  logic          i_tri,
   output logic [1:0]    o_data,
   output logic [1:0]    o_tri
);
   logic [1:0] pair;
   logic [1:0] tri_n;
   logic       gate;
   logic [1:0] data_q, tri_q;

   if (R == 2) begin : g_direct
      assign pair = i_word;
   end else begin : g_shift
      logic [R-1:0] sreg_q;
      always_ff @(posedge i_clk) begin
         if (i_rst)        sreg_q <= '0;
         else if (i_first) sreg_q <= i_word;
      end
      assign pair = i_first ? i_word[1:0] : sreg_q[{i_cnt, 1'b0} +: 2];
   end

   assign gate  = GATED && !i_en;
   assign tri_n = TRI_WE ? {2{~i_en}} : {2{i_tri}};

   always_ff @(posedge i_clk) begin
      if (i_rst) begin
         data_q <= {2{INIT}};
         tri_q  <= {2{TRI_INIT}};
      end else begin
         data_q <= gate ? {2{INIT}} : pair;
         tri_q  <= tri_n;
      end
   end

   assign o_data = data_q;
   assign o_tri  = tri_q;

   // R7: a lane-only reset forces the initial data value
   a_r7_lane_init: assert property (@(posedge i_clk) disable iff (i_rst_g)
      i_rst |=> (o_data == {2{INIT}}));
   // R8: a lane-only reset forces the tristate initial value
   a_r8_tri_init: assert property (@(posedge i_clk) disable iff (i_rst_g)
      i_rst |=> (o_tri == {2{TRI_INIT}}));

   if (GATED) begin : g_gate_chk
      // R9: an inactive enable holds a gated lane at its initial value
      a_r9_gate_hold: assert property (@(posedge i_clk) disable iff (i_rst_g)
         (!i_rst && !i_en) |=> (o_data == {2{INIT}}));
   end
   if (TRI_WE) begin : g_we_chk
      // R5: enable-driven tristate is the inverse of the enable bit
      a_r5_we_tri: assert property (@(posedge i_clk) disable iff (i_rst_g)
         !i_rst |=> (o_tri == {2{~$past(i_en)}}));
   end
endmodule

// File: rtl/nts_nibble_ser.sv
module nts_nibble_ser
   import nts_pkg::*;
#(
   parameter int               RATIO        = 8,
   parameter int               LANES        = NTS_LANES,
   parameter logic [LANES-1:0] TRI_FROM_WE  = '0,
   parameter bit               GATE_EN      = 1'b0,
   parameter logic [LANES-1:0] INIT_VAL     = '0,
   parameter bit               TRI_INIT     = 1'b1,
   parameter int               UNGATED_LANE = NTS_UNGATED
) (
   input  logic                   i_clk,
   input  logic                   i_rst,
   input  logic [LANES-1:0]       i_lane_rst,
   input  logic [LANES*RATIO-1:0] i_word,
   input  logic [RATIO/2-1:0]     i_wren,
   input  logic [LANES-1:0]       i_tri,
   output logic                   o_take,
   output logic [2*LANES-1:0]     o_data,
   output logic [2*LANES-1:0]     o_tri
);
   localparam int P  = RATIO / 2;
   localparam int CW = cnt_w(P);

   // elaboration-time configuration checks
   if (!(RATIO == 2 || RATIO == 4 || RATIO == 8)) begin : g_bad_ratio
      $error("nts_nibble_ser: RATIO must be 2, 4 or 8");
   end
   if (RATIO == 2 && (|TRI_FROM_WE)) begin : g_bad_tri_r6
      $error("nts_nibble_ser: R6 enable-driven tristate is illegal at ratio 2");
   end
   if (UNGATED_LANE >= LANES) begin : g_bad_ungated
      $error("nts_nibble_ser: UNGATED_LANE out of range");
   end

   logic [CW-1:0]          cnt;
   logic                   take;
   logic [LANES*RATIO-1:0] words_h2;
   logic [P-1:0]           we_h2;
   logic                   en_bit;

   nts_phase #(.P(P), .CW(CW)) phase_i (
      .i_clk (i_clk),
      .i_rst (i_rst),
      .o_cnt (cnt),
      .o_take(take)
   );

   nts_hold2 #(.W(LANES*RATIO)) word_hold_i (
      .i_clk (i_clk),
      .i_rst (i_rst),
      .i_load(take),
      .i_d   (i_word),
      .o_q   (words_h2)
   );

   nts_hold2 #(.W(P)) we_hold_i (
      .i_clk (i_clk),
      .i_rst (i_rst),
      .i_load(take),
      .i_d   (i_wren),
      .o_q   (we_h2)
   );

   if (P == 1) begin : g_en_direct
      assign en_bit = we_h2[0];
   end else begin : g_en_shift
      logic [P-1:0] we_sreg_q;
      always_ff @(posedge i_clk) begin
         if (i_rst)     we_sreg_q <= '0;
         else if (take) we_sreg_q <= we_h2;
      end
      assign en_bit = take ? we_h2[0] : we_sreg_q[cnt];
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      nts_lane #(
         .R       (RATIO),
         .CW      (CW),
         .INIT    (INIT_VAL[l]),
         .GATED   (GATE_EN && (l != UNGATED_LANE)),
         .TRI_WE  (TRI_FROM_WE[l]),
         .TRI_INIT(TRI_INIT)
      ) lane_i (
         .i_clk  (i_clk),
         .i_rst_g(i_rst),
         .i_rst  (i_rst | i_lane_rst[l]),
         .i_first(take),
         .i_cnt  (cnt),
         .i_word (words_h2[l*RATIO +: RATIO]),
         .i_en   (en_bit),
         .i_tri  (i_tri[l]),
         .o_data (o_data[2*l +: 2]),
         .o_tri  (o_tri[2*l +: 2])
      );
   end

   assign o_take = take;

   // R10: the ungated lane follows its data even while the enable is low
   a_r10_ungated_moves: assert property (@(posedge i_clk) disable iff (i_rst)
      (!en_bit && !i_lane_rst[UNGATED_LANE] && take)
         |=> (o_data[2*UNGATED_LANE +: 2] == $past(words_h2[UNGATED_LANE*RATIO +: 2])));
endmodule

// File: tb/nts_nibble_ser_tb_top.sv
module nts_run #(
   parameter int       R     = 8,
   parameter logic [5:0] TSEL  = 6'b0,
   parameter bit       GATE  = 1'b0,
   parameter logic [5:0] INIT  = 6'b0,
   parameter bit       TINIT = 1'b1
) (
   input  logic clk,
   output logic done,
   output int   n_chk,
   output int   n_fail
);
   localparam int P  = R / 2;
   localparam int L  = 6;
   localparam int NE = 16 * P;

   logic           rst;
   logic [L-1:0]   lrst, tin;
   logic [L*R-1:0] word;
   logic [P-1:0]   wren;
   logic           take;
   logic [2*L-1:0] od, ot;

   nts_nibble_ser #(
      .RATIO(R), .TRI_FROM_WE(TSEL), .GATE_EN(GATE),
      .INIT_VAL(INIT), .TRI_INIT(TINIT)
   ) dut_i (
      .i_clk(clk), .i_rst(rst), .i_lane_rst(lrst), .i_word(word),
      .i_wren(wren), .i_tri(tin), .o_take(take), .o_data(od), .o_tri(ot)
   );

   function automatic logic [R-1:0] wfn(input int m, input int l);
      int v;
      v = m * 37 + l * 11 + m * m + 5;
      return v[R-1:0];
   endfunction

   function automatic logic [P-1:0] wefn(input int m);
      int v;
      v = m * 5 + 3 + m / 4;
      return v[P-1:0];
   endfunction

   function automatic logic [L-1:0] tfn(input int e);
      int v;
      v = e * 13 + e / 3;
      return v[L-1:0];
   endfunction

   task automatic chk(input string tag, input int lane, input logic [1:0] act,
                      input logic [1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s ratio %0d lane %0d: actual %b expected %b",
                  tag, R, lane, act, exp);
      end
   endtask

   initial begin
      done = 1'b0; n_chk = 0; n_fail = 0;
      rst = 1'b1; lrst = '0; tin = '0; word = '0; wren = '0;
      @(negedge clk); @(posedge clk); @(negedge clk);
      // R7 R8: reset state on every lane
      for (int l = 0; l < L; l++) begin
         chk("R7", l, od[2*l +: 2], {2{INIT[l]}});
         chk("R8", l, ot[2*l +: 2], {2{TINIT}});
      end
      rst = 1'b0;
      for (int e = 0; e < NE; e++) begin
         if (e % P == 0) begin
            for (int l = 0; l < L; l++) word[l*R +: R] = wfn(e / P, l);
            wren = wefn(e / P);
         end
         tin = tfn(e);
         // R1: strobe marks the sampling edge
         chk("R1", 0, {1'b0, take}, {1'b0, (e % P == 0)});
         @(posedge clk); @(negedge clk);
         if (e >= 2 * P) begin
            int m, j;
            logic en;
            logic [R-1:0] w;
            logic [1:0] ed, et;
            m  = e / P - 2;
            j  = e % P;
            en = wefn(m)[j];
            for (int l = 0; l < L; l++) begin
               w  = wfn(m, l);
               ed = {w[2*j+1], w[2*j]};
               if (GATE && l != 1 && !en) begin
                  chk("R9", l, od[2*l +: 2], {2{INIT[l]}});
               end else if (l == 1) begin
                  chk("R10", l, od[2*l +: 2], ed);
               end else begin
                  chk("R2 R3", l, od[2*l +: 2], ed);
               end
               if (TSEL[l]) begin
                  et = {2{~en}};
                  chk("R5", l, ot[2*l +: 2], et);
               end else begin
                  et = {2{tfn(e)[l]}};
                  // R6: the ratio-2 nibble runs with direct tristate only
                  chk((R == 2) ? "R4 R6" : "R4", l, ot[2*l +: 2], et);
               end
            end
         end
      end
      // R7 R8: own reset of lane 3 while the nibble keeps running
      lrst = 6'b001000;
      for (int k = 0; k < 3; k++) begin
         @(posedge clk); @(negedge clk);
         chk("R7", 3, od[7:6], {2{INIT[3]}});
         chk("R8", 3, ot[7:6], {2{TINIT}});
      end
      lrst = '0;
      rst  = 1'b1;
      @(posedge clk); @(negedge clk);
      for (int l = 0; l < L; l++) begin
         chk("R7", l, od[2*l +: 2], {2{INIT[l]}});
         chk("R8", l, ot[2*l +: 2], {2{TINIT}});
      end
      done = 1'b1;
   end
endmodule

module nts_nibble_ser_tb_top;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic d8, d4, d2;
   int   c8, f8, c4, f4, c2, f2;

   nts_run #(.R(8), .TSEL(6'b101010), .GATE(1'b1), .INIT(6'b100110), .TINIT(1'b1))
      run8_i (.clk(clk), .done(d8), .n_chk(c8), .n_fail(f8));
   nts_run #(.R(4), .TSEL(6'b000110), .GATE(1'b0), .INIT(6'b011001), .TINIT(1'b0))
      run4_i (.clk(clk), .done(d4), .n_chk(c4), .n_fail(f4));
   nts_run #(.R(2), .TSEL(6'b000000), .GATE(1'b1), .INIT(6'b111000), .TINIT(1'b1))
      run2_i (.clk(clk), .done(d2), .n_chk(c2), .n_fail(f2));

   initial begin
      int wd_fail, total, failed;
      wd_fail = 0;
      for (int c = 0; c < 100000 && !(d8 === 1'b1 && d4 === 1'b1 && d2 === 1'b1); c++)
         @(posedge clk);
      if (!(d8 === 1'b1 && d4 === 1'b1 && d2 === 1'b1)) begin
         wd_fail = 1;
         $display("FAIL watchdog: runs unfinished, actual done=%b%b%b expected 111",
                  d8, d4, d2);
      end
      @(negedge clk);
      total  = c8 + c4 + c2 + wd_fail;
      failed = f8 + f4 + f2 + wd_fail;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule